// File: doc/BRIEF.md
# Boundary-Conduction Phase Switching Timer

This block times the gate of one boost power phase running at the boundary between continuous and discontinuous conduction. Each switching cycle begins with a gate pulse whose length comes from a programmable on-time word. The on-time is not derived from a fixed carrier period. After the pulse ends, the block waits for the inductor current to reach zero. A valley indication on the zero-current input signals this. The block then begins the next cycle, so the switching period follows the power stage rather than a clock divider.

Two protection timers bound the period. A minimum-period clamp delays a valley that comes too early, which caps the switching frequency; the default is 500 kHz at a 125 MHz clock. A restart timer starts a new cycle when no valley arrives, at about 17 kHz by default, which keeps the phase out of the audible band. The restart timer is also the only way switching can begin: a start request arms the phase, and the restart timer then launches the first cycle. For every cycle the block reports a start strobe, a flag that is set when the restart timer launched the cycle, and the measured period from turn-on to the valley. A controller that interleaves two phases can use these outputs.

Top module: `bcm_phase_timer`

## Requirements
- R1: After reset the gate stays low and no cycle starts until a one-clock start request arrives. The first cycle is then launched by the restart timer: the gate first reads high RESTART_PERIOD+1 clocks after the clock in which the request was driven, and restart_mode reads 1 for that cycle.
- R2: The gate stays high for exactly max(ton_word,1) clocks. ton_word is sampled in the clock in which a cycle starts, so a change to it affects only later cycles.
- R3: Once the gate is low and MIN_PERIOD has already elapsed, a recognised valley starts the next cycle in the very next clock.
- R4: A valley recognised before MIN_PERIOD clocks have elapsed since turn-on is held. The next cycle then starts exactly MIN_PERIOD clocks after the previous one.
- R5: If no valley is recognised, the next cycle starts RESTART_PERIOD clocks after the previous one. restart_mode reads 1 for that cycle, and period_meas is loaded with RESTART_PERIOD.
- R6: A rising edge on zcd_in is recognised three clocks after it is sampled (a two-flop synchronizer followed by an edge register). period_meas is loaded with the number of clocks from the cycle's first gate-high clock to that recognition, counted inclusively as elapsed cycle length. It becomes visible together with the next cycle start.
- R7: Rising edges of zcd_in that are recognised while the gate is high are ignored. If the input then stays high, no later valley is recognised for that cycle.
- R8: When phase_off is asserted, the gate is low one clock later. The phase returns to the idle state and stays silent, whatever zcd_in does, until a new start request arrives after phase_off is released.
- R9: cycle_start is a one-clock strobe that coincides with the first gate-high clock of each cycle.
- R10: A cycle started by a valley reads restart_mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_off | input | 1 | Forces the gate low and clears the cycle state |
| start_req | input | 1 | One-clock request that arms an idle phase |
| ton_word | input | TON_W | On-time in clocks (0 is treated as 1) |
| zcd_in | input | 1 | Asynchronous zero-current / valley indication, active on its rising edge |
| gate | output | 1 | Power switch gate drive |
| cycle_start | output | 1 | Strobe on the first gate-high clock of a cycle |
| restart_mode | output | 1 | High for a cycle launched by the restart timer |
| period_meas | output | CNT_W | Length of the last cycle up to its valley, or RESTART_PERIOD |

## Verification
Several rules are checked by assertions on every clock:
- the gate pulse ends exactly after the latched on-time;
- a valley-triggered turn-on never comes before the minimum period;
- a held valley never drives the gate;
- each recognised valley lasts a single clock;
- phase_off always pulls the gate low on the next clock;
- the start strobe always coincides with a high gate.

Only the directed scenarios can show the following:
- the exact spacing between cycles for early, late and missing valleys;
- the measured period values;
- that on-time changes are deferred to the next cycle;
- that valleys are rejected during the gate pulse;
- that an idle phase needs both a start request and the restart timer to begin.

// File: rtl/bcm_phase_pkg.sv
package bcm_phase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_ON    = 3'd2,
        ST_WAIT  = 3'd3,
        ST_HOLD  = 3'd4
    } phase_st_e;

    function automatic int unsigned max_width(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bcm_zcd_edge.sv
module bcm_zcd_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zcd_in,
    output logic valley
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t q, d;
    logic [SYNC_STAGES-1:0] chain_d;

    assign chain_d[0] = zcd_in;
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_chain
        assign chain_d[i] = q.sync[i-1];
    end

    always_comb begin
        d      = q;
        d.sync = chain_d;
        d.prev = q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valley = q.sync[SYNC_STAGES-1] & ~q.prev;

    // R6/R7: a recognised valley lasts exactly one clock
    p_valley_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valley |=> !valley);

endmodule

// File: rtl/bcm_cycle_ctrl.sv
module bcm_cycle_ctrl
    import bcm_phase_pkg::*;
#(
    parameter int TON_W          = 10,
    parameter int CNT_W          = 14,
    parameter int MIN_PERIOD     = 250,
    parameter int RESTART_PERIOD = 7353
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_off,
    input  logic             start_req,
    input  logic [TON_W-1:0] ton_word,
    input  logic             valley,
    output logic             gate,
    output logic             cycle_start,
    output logic             restart_mode,
    output logic [CNT_W-1:0] period_meas
);

    localparam logic [CNT_W:0] MIN_C = (CNT_W+1)'(MIN_PERIOD);
    localparam logic [CNT_W:0] RST_C = (CNT_W+1)'(RESTART_PERIOD);

    typedef struct packed {
        phase_st_e        state;
        logic [CNT_W-1:0] per;
        logic [TON_W-1:0] ton;
        logic             gate;
        logic             strobe;
        logic             rflag;
        logic [CNT_W-1:0] meas;
    } ctrl_st_t;

    ctrl_st_t q, d;

    logic [TON_W-1:0] ton_eff;
    logic [CNT_W:0]   per_inc;
    logic             start_now;
    logic             by_restart;

    assign ton_eff = (q.ton == '0) ? TON_W'(1) : q.ton;
    assign per_inc = {1'b0, q.per} + (CNT_W+1)'(1);

    always_comb begin
        d          = q;
        d.strobe   = 1'b0;
        start_now  = 1'b0;
        by_restart = 1'b0;

        unique case (q.state)
            ST_IDLE: begin
                d.per  = '0;
                d.gate = 1'b0;
                if (start_req) begin
                    d.state = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (per_inc >= RST_C) begin
                    start_now  = 1'b1;
                    by_restart = 1'b1;
                end else begin
                    d.per = per_inc[CNT_W-1:0];
                end
            end
            ST_ON: begin
                d.per = per_inc[CNT_W-1:0];
                if (per_inc >= (CNT_W+1)'(ton_eff)) begin
                    d.state = ST_WAIT;
                    d.gate  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (valley) begin
                    d.meas = per_inc[CNT_W-1:0];
                    if (per_inc >= MIN_C) begin
                        start_now = 1'b1;
                    end else begin
                        d.state = ST_HOLD;
                        d.per   = per_inc[CNT_W-1:0];
                    end
                end else if (per_inc >= RST_C) begin
                    d.meas     = RST_C[CNT_W-1:0];
                    start_now  = 1'b1;
                    by_restart = 1'b1;
                end else begin
                    d.per = per_inc[CNT_W-1:0];
                end
            end
            ST_HOLD: begin
                if (per_inc >= MIN_C) begin
                    start_now = 1'b1;
                end else begin
                    d.per = per_inc[CNT_W-1:0];
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.gate  = 1'b0;
            end
        endcase

        if (start_now) begin
            d.state  = ST_ON;
            d.per    = '0;
            d.ton    = ton_word;
            d.gate   = 1'b1;
            d.strobe = 1'b1;
            d.rflag  = by_restart;
        end

        if (phase_off) begin
            d.state  = ST_IDLE;
            d.per    = '0;
            d.gate   = 1'b0;
            d.strobe = 1'b0;
            d.rflag  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign gate         = q.gate;
    assign cycle_start  = q.strobe;
    assign restart_mode = q.rflag;
    assign period_meas  = q.meas;

    // R2: a pulse that ends normally has lasted the latched on-time
    p_on_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.gate) && q.state == ST_WAIT) |-> (q.per == CNT_W'(ton_eff)));

    // R4: a valley-launched turn-on respects the minimum period
    p_min_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.strobe && !q.rflag) |->
            (({1'b0, $past(q.per)} + (CNT_W+1)'(1)) >= MIN_C));

    // R4: while a valley is held the switch stays off
    p_hold_gate_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HOLD) |-> !q.gate);

    // R7: the gate is high exactly while the on-time runs
    p_gate_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.gate |-> (q.state == ST_ON));

endmodule

// File: rtl/bcm_phase_timer.sv
module bcm_phase_timer
    import bcm_phase_pkg::*;
#(
    parameter int TON_W          = 10,
    parameter int MIN_PERIOD     = 250,
    parameter int RESTART_PERIOD = 7353,
    parameter int SYNC_STAGES    = 2,
    localparam int CNT_W = int'(max_width($clog2(RESTART_PERIOD + 1), TON_W + 1))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_off,
    input  logic             start_req,
    input  logic [TON_W-1:0] ton_word,
    input  logic             zcd_in,
    output logic             gate,
    output logic             cycle_start,
    output logic             restart_mode,
    output logic [CNT_W-1:0] period_meas
);

    logic valley;

    bcm_zcd_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_zcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .zcd_in (zcd_in),
        .valley (valley)
    );

    bcm_cycle_ctrl #(
        .TON_W          (TON_W),
        .CNT_W          (CNT_W),
        .MIN_PERIOD     (MIN_PERIOD),
        .RESTART_PERIOD (RESTART_PERIOD)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_off    (phase_off),
        .start_req    (start_req),
        .ton_word     (ton_word),
        .valley       (valley),
        .gate         (gate),
        .cycle_start  (cycle_start),
        .restart_mode (restart_mode),
        .period_meas  (period_meas)
    );

    // R8: turning the phase off drops the gate on the next clock
    p_off_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_off |=> !gate);

    // R9: the start strobe always coincides with a high gate
    p_strobe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> gate);

endmodule

// File: tb/bcm_phase_timer_bench.sv
`timescale 1ns/1ps
module bcm_phase_timer_bench;

    localparam int TON_W = 8;
    localparam int MINP  = 40;
    localparam int RSTP  = 300;
    localparam int CW    = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             phase_off = 1'b0;
    logic             start_req = 1'b0;
    logic [TON_W-1:0] ton_word = 8'd10;
    logic             zcd_in = 1'b0;
    logic             gate;
    logic             cycle_start;
    logic             restart_mode;
    logic [CW-1:0]    period_meas;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bcm_phase_timer #(
        .TON_W          (TON_W),
        .MIN_PERIOD     (MINP),
        .RESTART_PERIOD (RSTP),
        .SYNC_STAGES    (2)
    ) u_bcm_phase_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_off    (phase_off),
        .start_req    (start_req),
        .ton_word     (ton_word),
        .zcd_in       (zcd_in),
        .gate         (gate),
        .cycle_start  (cycle_start),
        .restart_mode (restart_mode),
        .period_meas  (period_meas)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called on the negedge where cycle_start is seen; runs to the next one.
    task automatic run_cycle(input int k, input int hold, output int interval, output int width);
        interval = 0;
        width    = 1;
        forever begin
            @(negedge clk);
            interval++;
            if (interval == k)        zcd_in = 1'b1;
            if (interval == k + hold) zcd_in = 1'b0;
            if (cycle_start) break;
            if (gate) width++;
        end
        zcd_in = 1'b0;
        check("R9 strobe with gate", int'(gate), 1);
    endtask

    task automatic arm_and_first(input string req);
        int n;
        n = 0;
        start_req = 1'b1;
        @(negedge clk);
        n++;
        start_req = 1'b0;
        while (!cycle_start) begin
            @(negedge clk);
            n++;
        end
        check({req, " first start delay"}, n, RSTP + 1);
        check({req, " first cycle restart flag"}, int'(restart_mode), 1);
    endtask

    task automatic t_reset;
        int highs;
        check("R1 reset gate", int'(gate), 0);
        check("R1 reset strobe", int'(cycle_start), 0);
        check("R1 reset flag", int'(restart_mode), 0);
        check("R1 reset meas", int'(period_meas), 0);
        highs = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (gate || cycle_start) highs++;
        end
        check("R1 silent without start request", highs, 0);
    endtask

    task automatic t_valley;
        int iv, w;
        run_cycle(60, 2, iv, w);
        check("R3 late valley interval", iv, 63);
        check("R2 on-time width", w, 10);
        check("R6 measured period", int'(period_meas), 63);
        check("R10 valley cycle flag", int'(restart_mode), 0);
    endtask

    task automatic t_clamp;
        int iv, w;
        run_cycle(15, 2, iv, w);
        check("R4 clamped interval", iv, MINP);
        check("R4 R6 early valley measured", int'(period_meas), 18);
        check("R10 clamped cycle flag", int'(restart_mode), 0);
    endtask

    task automatic t_restart;
        int iv, w;
        run_cycle(-1, 0, iv, w);
        check("R5 restart interval", iv, RSTP);
        check("R5 restart flag", int'(restart_mode), 1);
        check("R5 restart meas", int'(period_meas), RSTP);
    endtask

    task automatic t_ton_change;
        int iv, w;
        ton_word = 8'd30;
        run_cycle(60, 2, iv, w);
        check("R2 old on-time kept", w, 10);
        check("R3 interval", iv, 63);
        // valley edge during the gate, input held high afterwards
        run_cycle(5, 100, iv, w);
        check("R2 new on-time", w, 30);
        check("R7 ignored valley interval", iv, RSTP);
        check("R7 ignored valley flag", int'(restart_mode), 1);
        ton_word = 8'd0;
        run_cycle(60, 2, iv, w);
        check("R2 on-time 30", w, 30);
        run_cycle(60, 2, iv, w);
        check("R2 zero on-time width", w, 1);
        check("R3 interval after short pulse", iv, 63);
    endtask

    task automatic t_disable;
        int iv, w, highs;
        ton_word = 8'd50;
        run_cycle(60, 2, iv, w);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R8 gate high before off", int'(gate), 1);
        phase_off = 1'b1;
        @(negedge clk);
        check("R8 gate low one clock after off", int'(gate), 0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        phase_off = 1'b0;
        highs = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            zcd_in = (i % 100) < 3;
            if (gate || cycle_start) highs++;
        end
        zcd_in = 1'b0;
        check("R8 silent after off", highs, 0);
        ton_word = 8'd10;
        arm_and_first("R8 R1 rearm");
        run_cycle(60, 2, iv, w);
        check("R3 after rearm", iv, 63);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        arm_and_first("R1");
        t_valley();
        t_clamp();
        t_restart();
        t_ton_change();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule